// File: doc/BRIEF.md
# Three-Lane 7:1 Serializer

This block turns a 21-bit parallel word into three serial data lanes and one forwarded-clock lane. It runs on a fast bit clock at seven times the rate of the pixel clock. The pixel clock enters as a level signal that stays in phase with the bit clock. The rising edge of the pixel clock, seen in the bit-clock domain, captures a word. Each lane then sends its seven bits, one per bit-clock cycle. The fourth lane sends a fixed seven-slot pattern in step with the data, so a receiver can recover both the clock and the frame boundaries.

An active-low powerdown input forces every lane to 0 and drops any frame in flight. When powerdown is released, nothing is sent until a fresh low-to-high transition of the pixel clock is seen. A pixel clock that is already high at release therefore cannot start a partial frame. If the pixel clock stops, the lanes finish the current frame and then idle at 0.

Top module: `tri_lane_serializer`

## Requirements
- R1: Lane k (k = 0, 1, 2) carries word bits 7k+6 down to 7k, most significant first, one bit per bit-clock cycle. The first bit is visible on the cycle after the capturing edge.
- R2: A word is captured on the bit-clock edge where pix_clk is high and was low at the previous edge. No other edge captures a word.
- R3: During the seven slots of a frame, the forwarded-clock lane outputs 1,1,0,0,0,1,1 in slot order.
- R4: When pix_clk has a period of exactly seven bit-clock cycles, frames follow each other with no idle slot between them.
- R5: While pwr_n is low at an edge, all four lanes are 0 after that edge, and any frame in flight is discarded.
- R6: After pwr_n returns high, no frame starts until pix_clk makes a new low-to-high transition. A pix_clk already high at release does not start a frame.
- R7: When no new capture follows, all lanes are 0 from the eighth cycle after the last capture onward.
- R8: A capture that arrives before seven slots have elapsed abandons the rest of the current frame and starts the new word at slot 0.
- R9: A synchronous active-high rst drives all lanes to 0 at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Fast bit clock, seven times the pixel rate |
| rst | input | 1 | Synchronous active-high reset |
| pix_clk | input | 1 | Pixel clock level, in phase with clk_bit |
| pwr_n | input | 1 | Active-low powerdown |
| word_in | input | 21 | Parallel word captured at a pixel-clock rise |
| lane_out | output | 3 | Serial data lanes, bit k is lane k |
| fwd_clk_out | output | 1 | Forwarded clock lane |

## Verification
The bench builds the block with its defaults: three lanes, seven slots and the 1100011 clock pattern. With these values every slot position of every lane is compared cycle by cycle against a stream model. Words of all ones, alternating bits and walking ones expose any swapped slice or reversed bit order. Stopped, shortened and powered-down pixel-clock sequences reach the idle, restart and release-while-high corners.

// File: rtl/tls_pkg.sv
package tls_pkg;

    localparam int unsigned LANE_CNT = 3;
    localparam int unsigned SLOT_CNT = 7;
    localparam logic [SLOT_CNT-1:0] FCLK_PAT = 7'b1100011;

    typedef struct packed {
        logic load;
        logic clear;
    } frame_ctl_t;

    function automatic logic pick_msb(input logic [SLOT_CNT-1:0] v);
        return v[SLOT_CNT-1];
    endfunction

endpackage

// File: rtl/tls_frame_ctrl.sv
module tls_frame_ctrl (
    input  logic                clk_bit,
    input  logic                rst,
    input  logic                pix_clk,
    input  logic                pwr_n,
    output tls_pkg::frame_ctl_t ctl
);

    logic pix_q;

    always_ff @(posedge clk_bit) begin
        if (rst) begin
            pix_q <= 1'b0;
        end else begin
            pix_q <= pix_clk;
        end
    end

    // R2 capture on a seen rise only; R5/R6 gated by powerdown
    always_comb begin
        ctl.clear = rst | ~pwr_n;
        ctl.load  = ~ctl.clear & pix_clk & ~pix_q;
    end

endmodule

// File: rtl/tls_shift_lane.sv
module tls_shift_lane #(
    parameter int unsigned SLOTS = tls_pkg::SLOT_CNT
) (
    input  logic                clk_bit,
    input  tls_pkg::frame_ctl_t ctl,
    input  logic [SLOTS-1:0]    load_val,
    output logic                ser_out
);

    logic [SLOTS-1:0] sr;

    // zeros shift in behind the frame, so the lane idles at 0 (R7)
    always_ff @(posedge clk_bit) begin
        if (ctl.clear) begin
            sr <= '0;
        end else if (ctl.load) begin
            sr <= load_val;
        end else begin
            sr <= {sr[SLOTS-2:0], 1'b0};
        end
    end

    assign ser_out = sr[SLOTS-1];

endmodule

// File: rtl/tri_lane_serializer.sv
module tri_lane_serializer #(
    parameter int unsigned LANES = tls_pkg::LANE_CNT,
    parameter int unsigned SLOTS = tls_pkg::SLOT_CNT,
    parameter logic [SLOTS-1:0] FCLK_PATTERN = tls_pkg::FCLK_PAT,
    localparam int unsigned WORD_W = LANES * SLOTS
) (
    input  logic              clk_bit,
    input  logic              rst,
    input  logic              pix_clk,
    input  logic              pwr_n,
    input  logic [WORD_W-1:0] word_in,
    output logic [LANES-1:0]  lane_out,
    output logic              fwd_clk_out
);

    tls_pkg::frame_ctl_t ctl;

    tls_frame_ctrl u_ctrl (
        .clk_bit (clk_bit),
        .rst     (rst),
        .pix_clk (pix_clk),
        .pwr_n   (pwr_n),
        .ctl     (ctl)
    );

    // R1 lane k takes slice k of the word
    for (genvar k = 0; k < LANES; k++) begin : g_data
        tls_shift_lane #(.SLOTS(SLOTS)) u_lane (
            .clk_bit  (clk_bit),
            .ctl      (ctl),
            .load_val (word_in[k*SLOTS +: SLOTS]),
            .ser_out  (lane_out[k])
        );
    end

    // R3 forwarded clock lane reloads a fixed pattern each frame
    tls_shift_lane #(.SLOTS(SLOTS)) u_fclk (
        .clk_bit  (clk_bit),
        .ctl      (ctl),
        .load_val (FCLK_PATTERN),
        .ser_out  (fwd_clk_out)
    );

endmodule

// File: rtl/tls_checker.sv
module tls_checker #(
    parameter int unsigned LANES = tls_pkg::LANE_CNT,
    parameter int unsigned SLOTS = tls_pkg::SLOT_CNT,
    parameter logic [SLOTS-1:0] FCLK_PATTERN = tls_pkg::FCLK_PAT,
    localparam int unsigned WORD_W = LANES * SLOTS,
    localparam int unsigned CW = $clog2(SLOTS + 1)
) (
    input logic              clk_bit,
    input logic              rst,
    input logic              pix_clk,
    input logic              pwr_n,
    input logic [WORD_W-1:0] word_in,
    input logic [LANES-1:0]  lane_out,
    input logic              fwd_clk_out
);

    logic          seen_q;
    logic [CW-1:0] slot_cnt;
    logic          start;
    logic [LANES-1:0] head_bits;

    assign start = pwr_n && pix_clk && !seen_q;

    always_comb begin
        for (int k = 0; k < LANES; k++) begin
            head_bits[k] = word_in[k*SLOTS + SLOTS - 1];
        end
    end

    always_ff @(posedge clk_bit) begin
        if (rst) begin
            seen_q   <= 1'b0;
            slot_cnt <= CW'(SLOTS);
        end else begin
            seen_q <= pix_clk;
            if (!pwr_n) begin
                slot_cnt <= CW'(SLOTS);
            end else if (start) begin
                slot_cnt <= '0;
            end else if (slot_cnt < CW'(SLOTS)) begin
                slot_cnt <= slot_cnt + 1'b1;
            end
        end
    end

    // R1
    first_bit_chk: assert property (@(posedge clk_bit) disable iff (rst)
        start |=> (lane_out == $past(head_bits)));

    // R3
    fclk_slot_chk: assert property (@(posedge clk_bit) disable iff (rst)
        (slot_cnt < CW'(SLOTS)) |-> (fwd_clk_out == FCLK_PATTERN[SLOTS - 1 - slot_cnt]));

    // R5
    pwrdn_zero_chk: assert property (@(posedge clk_bit) disable iff (rst)
        !pwr_n |=> (lane_out == '0 && !fwd_clk_out));

    // R7
    idle_zero_chk: assert property (@(posedge clk_bit) disable iff (rst)
        (slot_cnt == CW'(SLOTS)) |-> (lane_out == '0 && !fwd_clk_out));

endmodule

bind tri_lane_serializer tls_checker #(
    .LANES(LANES), .SLOTS(SLOTS), .FCLK_PATTERN(FCLK_PATTERN)
) u_chk (.*);

// File: tb/tri_lane_serializer_tb.sv
module tri_lane_serializer_tb;

    logic        clk_bit = 1'b0;
    logic        rst = 1'b1;
    logic        pix_clk = 1'b0;
    logic        pwr_n = 1'b0;
    logic [20:0] word_in = '0;
    logic [2:0]  lane_out;
    logic        fwd_clk_out;

    int n_cmp = 0;
    int n_bad = 0;
    logic prev_pix = 1'b0;
    logic [3:0] exp_q[$];
    string cur_tag = "R9";
    bit fclk_seq [7] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1};

    always #2 clk_bit = ~clk_bit;

    tri_lane_serializer u_dut (
        .clk_bit(clk_bit), .rst(rst), .pix_clk(pix_clk), .pwr_n(pwr_n),
        .word_in(word_in), .lane_out(lane_out), .fwd_clk_out(fwd_clk_out)
    );

    // driver: applies inputs and pushes the expected serial stream
    task automatic push_frame(input logic [20:0] w);
        exp_q.delete();
        for (int s = 0; s < 7; s++) begin
            logic [3:0] e;
            for (int k = 0; k < 3; k++) e[k] = w[7*k + 6 - s];
            e[3] = fclk_seq[s];
            exp_q.push_back(e);
        end
    endtask

    task automatic cycle(input logic r, input logic p, input logic pix, input logic [20:0] w);
        logic [3:0] exp_v;
        logic [3:0] got_v;
        @(negedge clk_bit);
        // monitor: pops and compares what the last edge produced
        exp_v = (exp_q.size() > 0) ? exp_q.pop_front() : 4'b0000;
        got_v = {fwd_clk_out, lane_out};
        n_cmp++;
        if (got_v !== exp_v) begin
            n_bad++;
            $display("FAIL %s at %0t: got %b expected %b", cur_tag, $time, got_v, exp_v);
        end
        rst = r; pwr_n = p; pix_clk = pix; word_in = w;
        if (r) begin
            exp_q.delete();
            prev_pix = 1'b0;
        end else begin
            if (!p) exp_q.delete();
            else if (pix && !prev_pix) push_frame(w);
            prev_pix = pix;
        end
    endtask

    task automatic frame(input logic [20:0] w, input int period, input int high);
        for (int i = 0; i < period; i++) cycle(1'b0, 1'b1, i < high, w);
    endtask

    initial begin
        repeat (200000) @(posedge clk_bit);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        cur_tag = "R9 reset";
        for (int i = 0; i < 4; i++) cycle(1'b1, 1'b0, i[0], 21'h1FFFFF);
        cur_tag = "R5 powerdown with toggling clock";
        for (int i = 0; i < 10; i++) cycle(1'b0, 1'b0, (i % 7) < 4, 21'h155555);
        cur_tag = "R6 release while pix high";
        cycle(1'b0, 1'b1, 1'b1, 21'h1FFFFF);
        cycle(1'b0, 1'b1, 1'b1, 21'h1FFFFF);
        cycle(1'b0, 1'b1, 1'b0, 21'h1FFFFF);
        cycle(1'b0, 1'b1, 1'b0, 21'h1FFFFF);
        cur_tag = "R1 R2 R3 R4 back-to-back frames";
        frame(21'h1FFFFF, 7, 4);
        frame(21'h000000, 7, 4);
        frame(21'h155555, 7, 4);
        frame(21'h0AAAAA, 7, 4);
        for (int b = 0; b < 21; b++) frame(21'(1) << b, 7, 4);
        frame(21'h12D687, 7, 4);
        cur_tag = "R7 pix stopped";
        for (int i = 0; i < 12; i++) cycle(1'b0, 1'b1, 1'b0, 21'h1C0E07);
        cur_tag = "R2 pix held high no recapture";
        frame(21'h0F0F0F, 7, 4);
        for (int i = 0; i < 10; i++) cycle(1'b0, 1'b1, 1'b1, 21'h1234AB);
        for (int i = 0; i < 2; i++) cycle(1'b0, 1'b1, 1'b0, 21'h1234AB);
        cur_tag = "R8 early restart";
        frame(21'h1FFFFF, 4, 2);
        frame(21'h0A5A5A, 3, 1);
        frame(21'h155555, 7, 4);
        for (int i = 0; i < 8; i++) cycle(1'b0, 1'b1, 1'b0, 21'h0);
        cur_tag = "R5 powerdown mid frame";
        cycle(1'b0, 1'b1, 1'b1, 21'h1FFFFF);
        cycle(1'b0, 1'b1, 1'b1, 21'h1FFFFF);
        cycle(1'b0, 1'b0, 1'b1, 21'h1FFFFF);
        for (int i = 0; i < 6; i++) cycle(1'b0, 1'b0, i < 2, 21'h1FFFFF);
        cur_tag = "R6 release while pix low then frame";
        cycle(1'b0, 1'b1, 1'b0, 21'h0);
        frame(21'h1B3C5D, 7, 4);
        cur_tag = "R9 reset mid frame";
        cycle(1'b0, 1'b1, 1'b1, 21'h1FFFFF);
        cycle(1'b0, 1'b1, 1'b1, 21'h1FFFFF);
        cycle(1'b1, 1'b1, 1'b1, 21'h1FFFFF);
        for (int i = 0; i < 9; i++) cycle(1'b0, 1'b1, 1'b1, 21'h1FFFFF);
        cycle(1'b0, 1'b1, 1'b0, 21'h0);
        cycle(1'b0, 1'b1, 1'b0, 21'h0);
        cur_tag = "R1 R4 after reset";
        frame(21'h0C3A96, 7, 4);
        frame(21'h13579B, 7, 4);
        for (int i = 0; i < 9; i++) cycle(1'b0, 1'b1, 1'b0, 21'h0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule